// File: doc/BRIEF.md
# Time-Stamped Record Frame Assembler

This block sits behind a bank of demodulator channels. Each channel delivers three 32-bit results for every record period: an in-phase sum, a quadrature sum and a total-power sum. When the record strobe is high, the block takes a snapshot of all results together with the current time stamp. It then sends them out as a single byte-wide frame over a valid/ready handshake.

A frame is a 16-byte header followed by the payload. The header holds four words:

- a fixed sync word,
- the time stamp taken at capture,
- a module identifier,
- a status word that reports records dropped since the previous header.

The time stamp does not count clock cycles. It counts rising edges of the slow secondary modulation carrier, and a distributed clear pulse sets it back to zero. Modules that share the carrier and the clear pulse therefore stamp the same record with the same number.

Only one frame is held at a time. A strobe that arrives while a frame is still going out is discarded, and the discard is reported in the next header.

Top module: `rec_frame_asm`

## Requirements
- R1: After reset, `tx_valid` is low, the time stamp is zero and every status flag and count is zero.
- R2: The time stamp increases by one in the cycle after `sec_carrier` is sampled high following a sample low (a rising edge). It holds its value in every other cycle, including while the carrier stays high.
- R3: A cycle with `stamp_clr` high sets the time stamp to zero. This takes priority over a rising carrier edge in the same cycle.
- R4: When `rec_stb` is high and no frame is outstanding, all results, `module_id` and the time stamp are captured. `tx_valid` rises in the next cycle.
- R5: A frame is 784 bytes (16 header bytes plus 4 × 3 × 64 payload bytes). The header words are sent most significant byte first, in this order:
  - header word 0 is the sync word (parameter, default 0xC3B59A1E),
  - header word 1 is the captured time stamp,
  - header word 2 is the captured `module_id`,
  - header word 3 is the status word.
- R6: Payload word k starts at byte 16+4k and is sent most significant byte first. Word k = 3c+s carries channel c (ascending) and stream s, where s=0 is in-phase, s=1 is quadrature and s=2 is total power. Channel c of each stream bus occupies bits [32c+31:32c].
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged. Every byte is delivered exactly once.
- R8: A strobe while a frame is outstanding is dropped, and the frame being sent is not altered. A strobe in the cycle that the final byte is accepted is not dropped: it is accepted, and the new frame's first byte follows in the next cycle.
- R9: The status word uses these fields, with all other bits zero:
  - bit 0: a record was dropped since the previous header,
  - bit 1: a sticky overflow flag, cleared only by reset,
  - bits 15:8: the number of dropped records, saturating at 255.
  Bit 0 and the count are cleared once they are loaded into a header.
- R10: After the final byte is accepted, `tx_valid` goes low unless a record was accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_carrier | input | 1 | Secondary modulation carrier, synchronous to clk |
| stamp_clr | input | 1 | Time stamp clear pulse |
| rec_stb | input | 1 | Record strobe: results are ready to capture |
| module_id | input | 32 | Module identifier placed in the header |
| dm_inph | input | 2048 | In-phase results, 32 bits per channel |
| dm_quad | input | 2048 | Quadrature results, 32 bits per channel |
| dm_tpow | input | 2048 | Total-power results, 32 bits per channel |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte is valid |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the stamp clear and a rising carrier edge. The bench raises the carrier in the cycle that carries the clear pulse. It then sends one more clean edge and expects a header stamp of exactly one.

The second pair is the acceptance of the final byte and a new record strobe. The bench drives the strobe in the handshake cycle of byte 783. It expects the next frame's sync byte on the very next cycle, with no idle gap and no drop recorded.

Drops are also provoked in bursts under irregular backpressure. The resulting counts and flags are judged in the following headers.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
    localparam int HDR_BYTES  = 16;
    localparam int HDR_WORDS  = 4;
    localparam int WORD_BYTES = 4;
    localparam int STREAMS    = 3;
    localparam int DROP_CW    = 8;

    typedef logic [31:0] word_t;

    // status word fields
    localparam int ST_DROP_BIT   = 0;
    localparam int ST_STICKY_BIT = 1;
    localparam int ST_CNT_LSB    = 8;

    function automatic word_t make_status(input logic drop, input logic sticky,
                                          input logic [DROP_CW-1:0] cnt);
        word_t w;
        w = '0;
        w[ST_DROP_BIT]                      = drop;
        w[ST_STICKY_BIT]                    = sticky;
        w[ST_CNT_LSB +: DROP_CW]            = cnt;
        return w;
    endfunction
endpackage

// File: rtl/rfa_stamp.sv
module rfa_stamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            carrier,
    input  logic            clr,
    output logic [TS_W-1:0] stamp
);
    typedef struct packed {
        logic            car;
        logic [TS_W-1:0] ts;
    } st_t;

    st_t q, d;
    logic rise;

    always_comb begin
        d    = q;
        rise = carrier && !q.car;
        d.car = carrier;
        if (clr)
            d.ts = '0;
        else if (rise)
            d.ts = q.ts + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stamp = q.ts;

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stamp == '0));
    // R2
    edge_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && carrier && !q.car) |=> (stamp == $past(stamp) + 1'b1));
    // R2
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(carrier && !q.car)) |=> $stable(stamp));
endmodule

// File: rtl/rfa_seq.sv
module rfa_seq
    import rfa_pkg::*;
#(
    parameter int    NUM_CH = 64,
    parameter word_t SYNC   = 32'hC3B5_9A1E,
    localparam int   WORDS  = NUM_CH * STREAMS,
    localparam int   FRAME_BYTES = HDR_BYTES + WORDS * WORD_BYTES,
    localparam int   CNT_W  = $clog2(FRAME_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rec_stb,
    input  word_t                      stamp,
    input  word_t                      module_id,
    input  logic [NUM_CH*32-1:0]       dm_inph,
    input  logic [NUM_CH*32-1:0]       dm_quad,
    input  logic [NUM_CH*32-1:0]       dm_tpow,
    input  logic                       tx_ready,
    output logic                       busy,
    output logic [CNT_W-1:0]           cnt,
    output logic [HDR_WORDS-1:0][31:0] hdr,
    output logic [WORDS-1:0][31:0]     snap
);
    localparam logic [CNT_W-1:0]   LAST    = CNT_W'(FRAME_BYTES - 1);
    localparam logic [DROP_CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic                     busy;
        logic [CNT_W-1:0]         cnt;
        word_t                    h_ts;
        word_t                    h_id;
        word_t                    h_st;
        logic                     drop;
        logic                     sticky;
        logic [DROP_CW-1:0]       dcnt;
        logic [WORDS-1:0][31:0]   snap;
    } st_t;

    st_t  q, d;
    logic hs, last_hs, free, take, lose;

    always_comb begin
        d       = q;
        hs      = q.busy && tx_ready;
        last_hs = hs && (q.cnt == LAST);
        free    = !q.busy || last_hs;
        take    = rec_stb && free;
        lose    = rec_stb && !free;

        if (hs) begin
            if (last_hs) begin
                d.busy = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (lose) begin
            d.drop   = 1'b1;
            d.sticky = 1'b1;
            if (q.dcnt != CNT_MAX) d.dcnt = q.dcnt + 1'b1;
        end

        if (take) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.h_ts = stamp;
            d.h_id = module_id;
            d.h_st = make_status(q.drop, q.sticky, q.dcnt);
            d.drop = 1'b0;
            d.dcnt = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                d.snap[c*STREAMS + 0] = dm_inph[c*32 +: 32];
                d.snap[c*STREAMS + 1] = dm_quad[c*32 +: 32];
                d.snap[c*STREAMS + 2] = dm_tpow[c*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign cnt  = q.cnt;
    assign snap = q.snap;
    assign hdr  = {q.h_st, q.h_id, q.h_ts, SYNC};

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_stb && q.busy && !(tx_ready && q.cnt == LAST))
            |=> (q.drop && q.sticky && $stable(q.snap) && $stable(q.h_ts)));
    // R4
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_stb && !q.busy) |=> (q.busy && q.cnt == '0));
    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy ? (q.cnt <= LAST) : (q.cnt == '0));
    // R9
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sticky |=> q.sticky);
endmodule

// File: rtl/rfa_byte_sel.sv
module rfa_byte_sel
    import rfa_pkg::*;
#(
    parameter int  NUM_CH = 64,
    localparam int WORDS  = NUM_CH * STREAMS,
    localparam int FRAME_BYTES = HDR_BYTES + WORDS * WORD_BYTES,
    localparam int CNT_W  = $clog2(FRAME_BYTES)
) (
    input  logic [CNT_W-1:0]           cnt,
    input  logic [HDR_WORDS-1:0][31:0] hdr,
    input  logic [WORDS-1:0][31:0]     snap,
    output logic [7:0]                 byte_o
);
    localparam logic [CNT_W-1:0] HDR_L = CNT_W'(HDR_BYTES);

    logic [CNT_W-1:0] pos;
    word_t            w;

    always_comb begin
        if (cnt < HDR_L) begin
            pos = cnt;
            w   = hdr[cnt[3:2]];
        end else begin
            pos = cnt - HDR_L;
            w   = snap[pos[CNT_W-1:2]];
        end
        case (pos[1:0])
            2'd0:    byte_o = w[31:24];
            2'd1:    byte_o = w[23:16];
            2'd2:    byte_o = w[15:8];
            default: byte_o = w[7:0];
        endcase
    end
endmodule

// File: rtl/rec_frame_asm.sv
module rec_frame_asm
    import rfa_pkg::*;
#(
    parameter int    NUM_CH = 64,
    parameter word_t SYNC   = 32'hC3B5_9A1E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_carrier,
    input  logic                 stamp_clr,
    input  logic                 rec_stb,
    input  logic [31:0]          module_id,
    input  logic [NUM_CH*32-1:0] dm_inph,
    input  logic [NUM_CH*32-1:0] dm_quad,
    input  logic [NUM_CH*32-1:0] dm_tpow,
    output logic [7:0]           tx_data,
    output logic                 tx_valid,
    input  logic                 tx_ready
);
    localparam int WORDS       = NUM_CH * STREAMS;
    localparam int FRAME_BYTES = HDR_BYTES + WORDS * WORD_BYTES;
    localparam int CNT_W       = $clog2(FRAME_BYTES);

    word_t                      stamp;
    logic                       busy;
    logic [CNT_W-1:0]           cnt;
    logic [HDR_WORDS-1:0][31:0] hdr;
    logic [WORDS-1:0][31:0]     snap;

    rfa_stamp #(.TS_W(32)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .carrier (sec_carrier),
        .clr     (stamp_clr),
        .stamp   (stamp)
    );

    rfa_seq #(.NUM_CH(NUM_CH), .SYNC(SYNC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_stb   (rec_stb),
        .stamp     (stamp),
        .module_id (module_id),
        .dm_inph   (dm_inph),
        .dm_quad   (dm_quad),
        .dm_tpow   (dm_tpow),
        .tx_ready  (tx_ready),
        .busy      (busy),
        .cnt       (cnt),
        .hdr       (hdr),
        .snap      (snap)
    );

    rfa_byte_sel #(.NUM_CH(NUM_CH)) u_sel (
        .cnt    (cnt),
        .hdr    (hdr),
        .snap   (snap),
        .byte_o (tx_data)
    );

    assign tx_valid = busy;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R5
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == SYNC[31:24]));
endmodule

// File: tb/rec_frame_asm_tb.sv
module rec_frame_asm_tb;
    localparam int          NCH   = 64;
    localparam int          FB    = 16 + 4 * 3 * NCH;
    localparam logic [31:0] SYNCW = 32'hC3B5_9A1E;
    localparam logic [31:0] MID   = 32'h0000_2A17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_carrier = 1'b0, stamp_clr = 1'b0, rec_stb = 1'b0, tx_ready = 1'b0;
    logic [31:0] module_id = MID;
    logic [NCH*32-1:0] dm_inph = '0, dm_quad = '0, dm_tpow = '0;
    logic [7:0] tx_data;
    logic tx_valid;
    logic [15:0] lfsr = 16'hACE1;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rec_frame_asm u_dut (
        .clk(clk), .rst_n(rst_n), .sec_carrier(sec_carrier), .stamp_clr(stamp_clr),
        .rec_stb(rec_stb), .module_id(module_id), .dm_inph(dm_inph), .dm_quad(dm_quad),
        .dm_tpow(dm_tpow), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int f, input int c, input int s);
        return {8'(f) ^ 8'h3C, 8'(c), 8'(s + 1), 8'(f + c)};
    endfunction

    function automatic logic [7:0] exp_byte(input int idx, input int f,
                                            input logic [31:0] ts, input logic [31:0] st);
        logic [31:0] w;
        if (idx < 16) begin
            case (idx / 4)
                0: w = SYNCW;
                1: w = ts;
                2: w = MID;
                default: w = st;
            endcase
        end else begin
            int wi;
            wi = (idx - 16) / 4;
            w  = pat(f, wi / 3, wi % 3);
        end
        return w[8*(3 - idx % 4) +: 8];
    endfunction

    task automatic set_bus(input int f);
        for (int c = 0; c < NCH; c++) begin
            dm_inph[c*32 +: 32] = pat(f, c, 0);
            dm_quad[c*32 +: 32] = pat(f, c, 1);
            dm_tpow[c*32 +: 32] = pat(f, c, 2);
        end
    endtask

    task automatic rise_edge();
        @(negedge clk) sec_carrier = 1'b1;
        repeat (3) @(negedge clk);
        sec_carrier = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_frame(input int f);
        @(negedge clk);
        tx_ready = 1'b0;
        set_bus(f);
        rec_stb = 1'b1;
        @(negedge clk);
        rec_stb = 1'b0;
        #1 chk(tx_valid == 1'b1, "R4 valid after strobe", 32'(tx_valid), 32'd1);
    endtask

    // rmode 0: ready always high; 1: pseudo-random ready
    task automatic drain(input int f, input logic [31:0] ets, input logic [31:0] est,
                         input int rmode, input int dfrom, input int dnum,
                         input bit chain, input int nf);
        int idx = 0, issued = 0;
        logic pv = 1'b0, pr = 1'b0;
        logic [7:0] pd = '0;
        while (idx < FB && !done) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = (rmode == 0) ? 1'b1 : lfsr[0];
            rec_stb = 1'b0;
            if (issued < dnum && idx >= dfrom) begin
                rec_stb = 1'b1;
                set_bus(f + 50);
                issued++;
            end
            if (chain && idx == FB - 1 && tx_ready) begin
                rec_stb = 1'b1;
                set_bus(nf);
            end
            #1;
            if (pv && !pr)
                chk(tx_valid && tx_data == pd, "R7 hold under backpressure",
                    {23'd0, tx_valid, tx_data}, {24'd1, pd});
            if (tx_valid && tx_ready) begin
                logic [7:0] e;
                e = exp_byte(idx, f, ets, est);
                chk(tx_data == e, idx < 16 ? "R5 header byte" : "R6 payload byte",
                    32'(tx_data), 32'(e));
                idx++;
            end else if (!tx_valid) begin
                chk(1'b0, "R7 valid dropped mid-frame", 32'(tx_valid), 32'd1);
            end
            pv = tx_valid; pr = tx_ready; pd = tx_data;
        end
        @(negedge clk);
        rec_stb = 1'b0;
        tx_ready = 1'b0;
        #1;
        if (chain)
            chk(tx_valid && tx_data == SYNCW[31:24], "R8 strobe on final byte accepted",
                {23'd0, tx_valid, tx_data}, {24'd1, SYNCW[31:24]});
        else
            chk(!tx_valid, "R10 idle after frame", 32'(tx_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 chk(!tx_valid, "R1 valid low in reset", 32'(tx_valid), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk(!tx_valid, "R1 valid low after reset", 32'(tx_valid), 32'd0);

        // R1 / R4 / R5 / R6: stamp and status zero, full-speed drain
        start_frame(0);
        drain(0, 32'd0, 32'h0, 0, 0, 0, 1'b0, 0);

        // R2: five rising edges, carrier held high between them
        for (int k = 0; k < 5; k++) rise_edge();
        start_frame(1);
        // R8: one strobe dropped mid-frame under random backpressure (R7)
        drain(1, 32'd5, 32'h0, 1, 300, 1, 1'b0, 0);

        for (int k = 0; k < 3; k++) rise_edge();
        start_frame(2);
        // R9: previous drop reported; chain next record on final byte (R8)
        drain(2, 32'd8, 32'h0000_0103, 1, 10, 1, 1'b1, 3);

        // R9: 261 drops must saturate the count at 255
        drain(3, 32'd8, 32'h0000_0103, 0, 1, 261, 1'b0, 0);

        // R3: clear and rising edge in the same cycle, then one clean edge
        @(negedge clk);
        sec_carrier = 1'b1;
        stamp_clr = 1'b1;
        @(negedge clk);
        stamp_clr = 1'b0;
        repeat (2) @(negedge clk);
        sec_carrier = 1'b0;
        repeat (2) @(negedge clk);
        rise_edge();
        start_frame(4);
        drain(4, 32'd1, 32'h0000_FF03, 1, 0, 0, 1'b0, 0);

        // R9: drop flag and count cleared, sticky overflow remains
        start_frame(5);
        drain(5, 32'd1, 32'h0000_0002, 0, 0, 0, 1'b0, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule